// File: doc/BRIEF.md
# Card Clock and Power Controller

This block generates the clock for a memory-card bus from the master clock and steps the card supply through its power states. Software programs it through a small register port that has two registers. The clock register selects a divide ratio, a full-rate bypass, an enable and a power-save mode. In power-save mode the card clock runs only while the bus-busy input is high. The power register holds a requested power state, a supply-voltage code and two command-line drive controls: open-drain versus push-pull, and rod control.

Two state machines sit under the register file. The power sequencer has three states. PWR_OFF is encoded 00, PWR_RAMP is encoded 10 and PWR_ON is encoded 11. A write of 00 goes to PWR_OFF. A write of 10 goes to PWR_RAMP. A write of 11 goes from PWR_RAMP or PWR_ON to PWR_ON, and from PWR_OFF to PWR_RAMP, so the supply always ramps before it is on. A write of 01 leaves the state where it is.

The divider has three states. From DV_STOP it goes to DV_LOW when running is allowed. From DV_LOW it goes to DV_HIGH at the end of the count while running is still allowed, and to DV_STOP as soon as running is withdrawn. From DV_HIGH it always goes to DV_LOW at the end of the count. The clock therefore stops only at a low level. A bypass gate switches the master clock itself to the output. The gate is updated on the falling master edge and is opened only while the divider is stopped.

Top module: `card_clkpwr_ctrl`

## Requirements
- R1: After reset both registers read zero, pwr_state is 00, and card_clk, card_clk_en, cmd_open_drain and rod_ctrl are low.
- R2: Power register bits [1:0] give the power state. Writing 10 gives 10 (ramping). Writing 11 while ramping or on gives 11 (on). Writing 00 gives 00 (off). The state is driven on pwr_state and read back in bits [1:0].
- R3: Writing 11 while off lands in 10, never directly in 11. Writing 01 leaves the power state unchanged.
- R4: Power register bits [5:2] hold the 4-bit voltage code, which is driven on volt_code and read back.
- R5: Power register bit 6 drives cmd_open_drain, and clearing it selects push-pull. Bit 7 drives rod_ctrl. Both read back.
- R6: Clock register bits [7:0] hold the divide value, bit 8 the enable, bit 9 power-save and bit 10 bypass. All of these read back, and the unused bits read zero.
- R7: With enable set and bypass clear, each high phase and each low phase of card_clk lasts div+1 master cycles, which gives a period of 2*(div+1).
- R8: With bypass and enable set, card_clk equals the master clock whatever the divide value is.
- R9: With power-save set, card_clk stays low while bus_busy is low and runs while it is high. With power-save clear, card_clk runs regardless of bus_busy.
- R10: When running is withdrawn during a high phase, that phase still lasts the full div+1 cycles before the clock stays low. No high pulse is ever shorter than its count.
- R11: Writing zero to both registers stops card_clk and turns power off. A later rewrite restarts the clock and the power sequence from off.
- R12: card_clk_en is high while the divider or the bypass gate is running and low when the clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 clock register, 1 power register |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read source: 0 clock register, 1 power register |
| rd_data | output | 16 | Read data (combinational) |
| bus_busy | input | 1 | Bus activity, gates the clock in power-save mode |
| card_clk | output | 1 | Card bus clock |
| card_clk_en | output | 1 | Card clock running |
| cmd_open_drain | output | 1 | 1 open-drain, 0 push-pull command drive |
| rod_ctrl | output | 1 | Rod control output |
| volt_code | output | 4 | Supply voltage code |
| pwr_state | output | 2 | Power state: 00 off, 10 ramping, 11 on |

## Verification
A register write takes effect at the next rising edge. Read-back, pwr_state and the drive pins are therefore compared at the falling edge that follows the write. The divider enters DV_LOW one edge after it is enabled and rises div+1 edges later. For this reason the bench waits for an observed rising edge of card_clk and then counts whole high and low phases, sampling at falling master edges, instead of predicting an absolute cycle. The bypass gate opens on the falling edge after the divider has stopped. Bypass is therefore checked only after a settling interval, by sampling a quarter period into each master clock phase. The expected values are queued by the driver and popped by the monitor in the same order.

// File: rtl/card_cp_pkg.sv
package card_cp_pkg;
    typedef enum logic [1:0] {
        PWR_OFF  = 2'b00,
        PWR_RAMP = 2'b10,
        PWR_ON   = 2'b11
    } pwr_st_t;

    typedef enum logic [1:0] {
        DV_STOP = 2'b00,
        DV_LOW  = 2'b01,
        DV_HIGH = 2'b10
    } dv_st_t;
endpackage

// File: rtl/card_pwr_fsm.sv
module card_pwr_fsm
    import card_cp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_wr,
    input  logic [1:0] req_code,
    output logic [1:0] pwr_state
);
    pwr_st_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PWR_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (req_wr) begin
            unique case (req_code)
                2'b00: st_d = PWR_OFF;
                2'b10: st_d = PWR_RAMP;
                2'b11: st_d = (st_q == PWR_OFF) ? PWR_RAMP : PWR_ON;
                default: st_d = st_q;
            endcase
        end
    end

    always_comb begin
        pwr_state = st_q;
    end

    a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state != 2'b01);

    a_r3_no_direct_on: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_state) == 2'b00) |-> (pwr_state != 2'b11));
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
    import card_cp_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             div_clk,
    output logic             active
);
    dv_st_t           st_q, st_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] lim_q, lim_d;
    logic             hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DV_STOP;
            cnt_q <= '0;
            lim_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            lim_q <= lim_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        lim_d = lim_q;
        unique case (st_q)
            DV_STOP: begin
                cnt_d = '0;
                if (run) begin
                    st_d  = DV_LOW;
                    lim_d = div_val;
                end
            end
            DV_LOW: begin
                if (!run) begin
                    st_d  = DV_STOP;
                    cnt_d = '0;
                end else if (cnt_q == lim_q) begin
                    st_d  = DV_HIGH;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            DV_HIGH: begin
                if (cnt_q == lim_q) begin
                    st_d  = DV_LOW;
                    cnt_d = '0;
                    lim_d = div_val;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                st_d  = DV_STOP;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_q <= 1'b0;
        else        hi_q <= (st_d == DV_HIGH);
    end

    assign div_clk = hi_q;
    assign active  = (st_q != DV_STOP);

    a_r10_full_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_clk) |-> ($past(cnt_q) == $past(lim_q)));

    a_r10_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DV_STOP) |-> !div_clk);
endmodule

// File: rtl/card_clk_bypass_gate.sv
module card_clk_bypass_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic div_clk,
    output logic gate_on,
    output logic card_clk
);
    logic gate_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= want;
    end

    assign gate_on  = gate_q;
    assign card_clk = (clk & gate_q) | div_clk;

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |-> !div_clk);
endmodule

// File: rtl/card_clkpwr_ctrl.sv
module card_clkpwr_ctrl #(
    parameter int DIV_W  = 8,
    parameter int VOLT_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              bus_busy,
    output logic              card_clk,
    output logic              card_clk_en,
    output logic              cmd_open_drain,
    output logic              rod_ctrl,
    output logic [VOLT_W-1:0] volt_code,
    output logic [1:0]        pwr_state
);
    localparam int CK_EN  = DIV_W;
    localparam int CK_PS  = DIV_W + 1;
    localparam int CK_BYP = DIV_W + 2;
    localparam int CK_W   = DIV_W + 3;
    localparam int PW_VLO = 2;
    localparam int PW_OD  = VOLT_W + 2;
    localparam int PW_ROD = VOLT_W + 3;
    localparam int PW_W   = VOLT_W + 4;

    logic [CK_W-1:0]   ck_q;
    logic [VOLT_W-1:0] volt_q;
    logic              od_q, rod_q;
    logic              run, run_div, want_gate;
    logic              div_clk, div_active, gate_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_q   <= '0;
            volt_q <= '0;
            od_q   <= 1'b0;
            rod_q  <= 1'b0;
        end else if (wr_en) begin
            if (!wr_sel) begin
                ck_q <= wr_data[CK_W-1:0];
            end else begin
                volt_q <= wr_data[PW_VLO +: VOLT_W];
                od_q   <= wr_data[PW_OD];
                rod_q  <= wr_data[PW_ROD];
            end
        end
    end

    card_pwr_fsm u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_wr    (wr_en & wr_sel),
        .req_code  (wr_data[1:0]),
        .pwr_state (pwr_state)
    );

    assign run       = ck_q[CK_EN] & (~ck_q[CK_PS] | bus_busy);
    assign run_div   = run & ~ck_q[CK_BYP];
    assign want_gate = run & ck_q[CK_BYP] & ~div_active;

    card_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_div),
        .div_val (ck_q[DIV_W-1:0]),
        .div_clk (div_clk),
        .active  (div_active)
    );

    card_clk_bypass_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .want     (want_gate),
        .div_clk  (div_clk),
        .gate_on  (gate_on),
        .card_clk (card_clk)
    );

    assign card_clk_en    = div_active | gate_on;
    assign cmd_open_drain = od_q;
    assign rod_ctrl       = rod_q;
    assign volt_code      = volt_q;

    always_comb begin
        rd_data = '0;
        if (rd_sel) begin
            rd_data[1:0]               = pwr_state;
            rd_data[PW_VLO +: VOLT_W]  = volt_q;
            rd_data[PW_OD]             = od_q;
            rd_data[PW_ROD]            = rod_q;
        end else begin
            rd_data[CK_W-1:0] = ck_q;
        end
    end

    a_r9_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_clk) |-> $past(run));

    a_r12_en_when_toggling: assert property (@(posedge clk) disable iff (!rst_n)
        div_clk |-> card_clk_en);

    initial begin
        a_r6_fits: assert (PW_W <= DATA_W && CK_W <= DATA_W);
    end
endmodule

// File: tb/tb_card_clkpwr_ctrl.sv
module tb_card_clkpwr_ctrl;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [15:0] rd_data;
    logic        bus_busy = 1'b0;
    logic        card_clk, card_clk_en, cmd_open_drain, rod_ctrl;
    logic [3:0]  volt_code;
    logic [1:0]  pwr_state;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct { string tag; int val; } exp_t;
    exp_t exp_q[$];

    card_clkpwr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .bus_busy(bus_busy), .card_clk(card_clk), .card_clk_en(card_clk_en),
        .cmd_open_drain(cmd_open_drain), .rod_ctrl(rod_ctrl),
        .volt_code(volt_code), .pwr_state(pwr_state)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic push_exp(input string tag, input int val);
        exp_t e;
        e.tag = tag;
        e.val = val;
        exp_q.push_back(e);
    endtask

    task automatic pop_cmp(input int act);
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (act != e.val) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", e.tag, act, e.val);
        end
    endtask

    task automatic wr(input logic sel, input int data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output int val);
        rd_sel = sel;
        #1;
        val = int'(rd_data);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_rise(output bit ok);
        logic prev;
        ok = 1'b0;
        prev = card_clk;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!prev && card_clk) begin ok = 1'b1; break; end
            prev = card_clk;
        end
    endtask

    task automatic count_level(input logic lvl, output int n);
        n = 1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (card_clk !== lvl) break;
            n++;
        end
    endtask

    task automatic measure_div(input string tag, input int div);
        bit ok;
        int hi, lo;
        wait_rise(ok);
        push_exp({tag, " rise seen"}, 1);
        pop_cmp(int'(ok));
        count_level(1'b1, hi);
        count_level(1'b0, lo);
        push_exp({tag, " high len"}, div + 1);
        pop_cmp(hi);
        push_exp({tag, " low len"}, div + 1);
        pop_cmp(lo);
    endtask

    task automatic count_highs(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (card_clk) highs++;
            @(posedge clk);
            #(PERIOD/4);
            if (card_clk) highs++;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int v, h;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); push_exp("R1 clock reg", 0); pop_cmp(v);
        rd(1'b1, v); push_exp("R1 power reg", 0); pop_cmp(v);
        push_exp("R1 outputs", 0);
        pop_cmp(int'({card_clk, card_clk_en, cmd_open_drain, rod_ctrl, pwr_state}));

        // R2 / R4 / R5: bring-up sequence with voltage 15, open-drain, rod
        wr(1'b1, (15 << 2) | (1 << 6));
        push_exp("R4 volt_code", 15); pop_cmp(int'(volt_code));
        push_exp("R5 open drain on", 1); pop_cmp(int'(cmd_open_drain));
        wr(1'b1, 2'b10 | (15 << 2) | (1 << 6) | (1 << 7));
        push_exp("R2 ramp state", 2); pop_cmp(int'(pwr_state));
        push_exp("R5 rod on", 1); pop_cmp(int'(rod_ctrl));
        wr(1'b1, 2'b11 | (15 << 2) | (1 << 6) | (1 << 7));
        rd(1'b1, v); push_exp("R2 on readback", 'hFF); pop_cmp(v);
        // R3: 01 ignored
        wr(1'b1, 2'b01 | (15 << 2) | (1 << 6) | (1 << 7));
        push_exp("R3 code 01 ignored", 3); pop_cmp(int'(pwr_state));
        // R5: clear open-drain -> push-pull
        wr(1'b1, 2'b11 | (15 << 2) | (1 << 7));
        push_exp("R5 push-pull", 0); pop_cmp(int'(cmd_open_drain));
        rd(1'b1, v); push_exp("R5 readback", 'hBF); pop_cmp(v);

        // R6 clock reg readback, upper bits dropped
        wr(1'b0, 'hF800 | (1 << 10) | (1 << 9) | 8'h5A);
        rd(1'b0, v); push_exp("R6 clock readback", 'h65A); pop_cmp(v);
        wr(1'b0, 0);
        idle(5);

        // R7 divider ratios
        wr(1'b0, (1 << 8) | 2);
        measure_div("R7 div2", 2);
        push_exp("R12 clk_en running", 1); pop_cmp(int'(card_clk_en));
        wr(1'b0, (1 << 8) | 0);
        idle(6);
        measure_div("R7 div0", 0);
        wr(1'b0, (1 << 8) | 29);
        idle(70);
        measure_div("R7 div29", 29);

        // R10: drop enable just after a rising edge
        wr(1'b0, (1 << 8) | 3);
        idle(12);
        wait_rise(ok);
        fork
            wr(1'b0, 3);
            count_level(1'b1, h);
        join
        push_exp("R10 high phase kept", 4); pop_cmp(h);
        count_highs(20, h);
        push_exp("R10 stays low", 0); pop_cmp(h);
        push_exp("R12 clk_en stopped", 0); pop_cmp(int'(card_clk_en));

        // R8 bypass
        wr(1'b0, (1 << 10) | (1 << 8) | 7);
        idle(20);
        count_highs(10, h);
        push_exp("R8 bypass high samples", 10); pop_cmp(h);
        push_exp("R12 clk_en bypass", 1); pop_cmp(int'(card_clk_en));
        @(negedge clk); #(PERIOD/4);
        push_exp("R8 low in low phase", 0); pop_cmp(int'(card_clk));
        wr(1'b0, 0);
        idle(5);

        // R9 power-save
        bus_busy = 1'b0;
        wr(1'b0, (1 << 9) | (1 << 8) | 1);
        count_highs(40, h);
        push_exp("R9 idle bus no clock", 0); pop_cmp(h);
        bus_busy = 1'b1;
        measure_div("R9 busy bus", 1);
        bus_busy = 1'b0;
        idle(6);
        wr(1'b0, (1 << 8) | 1);
        measure_div("R9 no psave idle bus", 1);

        // R11 shutdown by zero writes, then restart
        wr(1'b0, 0);
        wr(1'b1, 0);
        idle(6);
        count_highs(20, h);
        push_exp("R11 clock stopped", 0); pop_cmp(h);
        push_exp("R11 power off", 0); pop_cmp(int'(pwr_state));
        wr(1'b1, 2'b11 | (15 << 2));
        push_exp("R3 11 from off ramps", 2); pop_cmp(int'(pwr_state));
        wr(1'b1, 2'b11 | (15 << 2));
        push_exp("R11 on after restart", 3); pop_cmp(int'(pwr_state));
        wr(1'b0, (1 << 8) | 2);
        measure_div("R11 clock restart", 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule